// File: doc/BRIEF.md
# Scrambled NRZI Serial Line Encoder and Loopback Decoder

This block turns a stream of 10-bit parallel video words into a single-bit line signal. All of its logic runs on the bit clock, which is ten times the word rate. Every tenth bit-clock cycle the block raises `tx_take`. At the next rising edge it captures `tx_word` if `tx_valid` is high. If `tx_valid` is low it captures a word of zeros instead. The word is sent least significant bit first, with no gap between words.

Each serial bit passes through a self-synchronizing scrambler with generator x^9 + x^4 + 1. A first-order x + 1 stage then converts the scrambled bits into NRZI, so a receiver does not depend on the line's polarity. The block supports line rates of 143, 177.3, 270 and 360 Mb/s; the word rate is always one tenth of the bit rate.

A receive path on the same bit clock undoes both stages. It turns `rx_line` back into scrambled NRZ and then into plain serial data on `rx_bit`. When `rx_line` is fed from `tx_line`, the parallel words can be checked end to end. The receive path does not find word boundaries. The user counts bit positions from the known fixed latency.

Top module: `sdi_serial_codec`

## Requirements
- R1: `tx_take` is high for exactly one bit-clock cycle in every ten. The first of these is the first cycle after reset is released. The word on `tx_word` is captured at the rising edge that ends a `tx_take` cycle.
- R2: A captured word is sent least significant bit first, one bit per cycle. The bits of consecutive words follow each other with no idle cycle between them.
- R3: If `tx_valid` is low at the capturing edge, the ten bits sent in that word slot are all zero.
- R4: Let d be the serial data bit and c the scrambled bit. Then c(t) = d(t) XOR c(t-4) XOR c(t-9). The scrambler history is cleared by reset. The relation holds from any history, including all zeros, so a nonzero data bit always leaves that state.
- R5: `tx_line` toggles in a cycle exactly when the scrambled bit of the previous cycle was 1, and holds otherwise. Bit i of a word captured at edge n reaches `tx_line` in the cycle after edge n+2+i.
- R6: While reset is held, and in the first cycle after reset is released, `tx_line` and `rx_bit` are 0 and `tx_take` is 1.
- R7: With `rx_line` driven by `tx_line`, bit i of a word captured at edge n appears on `rx_bit` in the cycle after edge n+4+i.
- R8: With `rx_line` driven by the inverse of `tx_line`, `rx_bit` carries the same data as in R7 from the fourteenth cycle after reset onward.
- R9: If `rx_line` is wrong for one bit-clock cycle, `rx_bit` is wrong only within the following 12 cycles. From the 13th cycle after the fault, it matches R7 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every register uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_word | input | 10 | Parallel word to send |
| tx_valid | input | 1 | Qualifies `tx_word` at the capturing edge |
| tx_take | output | 1 | High in the cycle whose ending edge captures a word |
| tx_line | output | 1 | Scrambled NRZI line bit |
| rx_line | input | 1 | Line bit into the receive path |
| rx_bit | output | 1 | Recovered serial data bit |

## Verification
The hardest case to reach from the ports is the decoder recovering from a history that disagrees with the transmitter. In a clean loopback both sides leave reset in matching all-zero states, so that case never occurs. The bench creates it in two ways. It inverts the line from reset onward, which feeds the NRZI decoder a false first transition. It also flips a single line bit in the middle of a pseudo-random stream. In both cases the bench checks that `rx_bit` agrees with an independent model of the data once the stated recovery window has passed.

// File: rtl/sdi_codec_pkg.sv
// Shared constants for the scrambled NRZI line codec.
// Assumes a single bit clock for both directions.
package sdi_codec_pkg;
    // Parallel word width.
    localparam int WORD_W    = 10;
    // Scrambler generator x^SCR_LONG + x^SCR_SHORT + 1.
    localparam int SCR_LONG  = 9;
    localparam int SCR_SHORT = 4;

    // Direction of a self-synchronizing scrambler stage.
    typedef enum logic {
        SCR_DIR_ENCODE = 1'b0,
        SCR_DIR_DECODE = 1'b1
    } scr_dir_e;
endpackage

// File: rtl/sdi_word_serializer.sv
// Parallel-to-serial converter.
// A one-hot slot counter raises take_o in the last bit slot of each word.
// At the edge that ends that slot, it loads either the input word or a
// zero fill word. The word is then shifted out LSB first.
// Assumes: reset leaves the counter in the last slot, so the first word is
// captured at the first edge after reset is released.
module sdi_word_serializer #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              valid_i,
    output logic              take_o,
    output logic              bit_o
);
    localparam logic [WORD_W-1:0] SLOT_LAST = WORD_W'(1) << (WORD_W - 1);

    logic [WORD_W-1:0] slot_q;
    logic [WORD_W-1:0] shreg_q;

    // Take strobe: the final slot of the current word.
    always_comb take_o = slot_q[WORD_W-1];

    // One-hot slot ring: rotates by one position every bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= SLOT_LAST;
        else        slot_q <= {slot_q[WORD_W-2:0], slot_q[WORD_W-1]};
    end

    // Shift register: load at the take edge, shift right otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      shreg_q <= '0;
        else if (take_o) shreg_q <= valid_i ? word_i : '0;
        else             shreg_q <= {1'b0, shreg_q[WORD_W-1:1]};
    end

    // The serial bit is the LSB of the shift register.
    always_comb bit_o = shreg_q[0];
endmodule

// File: rtl/sdi_sync_scrambler.sv
// Self-synchronizing scrambler/descrambler for x^LONG + x^SHORT + 1.
// ENCODE: the history holds past outputs, so it is a scrambler.
// DECODE: the history holds past inputs, so it is a descrambler.
// The output is registered, which adds one cycle of latency.
// Assumes 1 < SHORT < LONG.
module sdi_sync_scrambler
    import sdi_codec_pkg::*;
#(
    parameter int       LONG  = 9,
    parameter int       SHORT = 4,
    parameter scr_dir_e DIR   = SCR_DIR_ENCODE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [LONG-1:0] hist_q;
    logic            mix;
    logic            hist_in;

    // Feedback: the current bit combined with the two tapped history bits.
    always_comb mix = din ^ hist_q[SHORT-1] ^ hist_q[LONG-1];

    // Select what the history records, according to the direction.
    generate
        if (DIR == SCR_DIR_ENCODE) begin : g_enc
            always_comb hist_in = mix;
        end else begin : g_dec
            always_comb hist_in = din;
        end
    endgenerate

    // History shift register: entry k holds the bit from k+1 cycles back.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[LONG-2:0], hist_in};
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= 1'b0;
        else        dout <= mix;
    end
endmodule

// File: rtl/sdi_nrzi_stage.sv
// NRZI converter for the x + 1 polynomial.
// Encode: the line toggles on a 1 and holds on a 0.
// Decode: the output is the XOR of the current and previous line bits,
// which is the same whichever way the line is inverted.
// Both directions have one register of latency.
module sdi_nrzi_stage
    import sdi_codec_pkg::*;
#(
    parameter scr_dir_e DIR = SCR_DIR_ENCODE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (DIR == SCR_DIR_ENCODE) begin : g_enc
            logic level_q;
            // Line level: flips on each incoming 1.
            always_ff @(posedge clk) begin
                if (!rst_n) level_q <= 1'b0;
                else        level_q <= level_q ^ din;
            end
            always_comb dout = level_q;
        end else begin : g_dec
            logic prev_q;
            logic diff_q;
            // Previous line sample, kept for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= din;
            end
            // Transition detector output register.
            always_ff @(posedge clk) begin
                if (!rst_n) diff_q <= 1'b0;
                else        diff_q <= din ^ prev_q;
            end
            always_comb dout = diff_q;
        end
    endgenerate
endmodule

// File: rtl/sdi_serial_codec.sv
// Top level of the scrambled NRZI line codec.
// Transmit: serializer -> scrambler -> NRZI encoder -> tx_line.
// Receive:  rx_line -> NRZI decoder -> descrambler -> rx_bit.
// Assumes both directions share the bit clock. Word framing on the receive
// side is left to the user, who counts from the fixed latency.
module sdi_serial_codec
    import sdi_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_valid,
    output logic              tx_take,
    output logic              tx_line,
    input  logic              rx_line,
    output logic              rx_bit
);
    logic ser_bit;
    logic scr_bit;
    logic nrz_rx;

    sdi_word_serializer #(.WORD_W(WORD_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (tx_word),
        .valid_i (tx_valid),
        .take_o  (tx_take),
        .bit_o   (ser_bit)
    );

    sdi_sync_scrambler #(.LONG(SCR_LONG), .SHORT(SCR_SHORT), .DIR(SCR_DIR_ENCODE)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ser_bit),
        .dout  (scr_bit)
    );

    sdi_nrzi_stage #(.DIR(SCR_DIR_ENCODE)) u_nrzi_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (scr_bit),
        .dout  (tx_line)
    );

    sdi_nrzi_stage #(.DIR(SCR_DIR_DECODE)) u_nrzi_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (nrz_rx)
    );

    sdi_sync_scrambler #(.LONG(SCR_LONG), .SHORT(SCR_SHORT), .DIR(SCR_DIR_DECODE)) u_dscr (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (nrz_rx),
        .dout  (rx_bit)
    );
endmodule

// File: rtl/sdi_serial_codec_chk.sv
// Property checker for sdi_serial_codec. It is attached by the bind below.
// It watches the transmit side: the take cadence, the word load, the zero
// fill and the NRZI transitions.
module sdi_serial_codec_chk
    import sdi_codec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] tx_word,
    input logic              tx_valid,
    input logic              tx_take,
    input logic              tx_line,
    input logic              ser_bit,
    input logic              scr_bit
);
    logic [7:0] gap_q;
    logic       armed_q;

    // Independent slot counter, used to check the take cadence.
    always_ff @(posedge clk) begin
        if (!rst_n)       gap_q <= 8'(WORD_W - 1);
        else if (tx_take) gap_q <= '0;
        else              gap_q <= gap_q + 8'd1;
    end

    // Goes high once a full cycle has passed since reset, so $past is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_take_cadence_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take == (gap_q == 8'(WORD_W - 1)));

    assert_lsb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(tx_take && tx_valid) |-> ser_bit == $past(tx_word[0]));

    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(tx_take && !tx_valid) |-> !ser_bit);

    assert_nrzi_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((tx_line != $past(tx_line)) == $past(scr_bit)));
endmodule

bind sdi_serial_codec sdi_serial_codec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_word  (tx_word),
    .tx_valid (tx_valid),
    .tx_take  (tx_take),
    .tx_line  (tx_line),
    .ser_bit  (ser_bit),
    .scr_bit  (scr_bit)
);

// File: tb/sdi_serial_codec_bench.sv
// Directed bench for sdi_serial_codec. Each scenario task resets the block,
// runs a word pattern through the loopback and reports its own failures.
module sdi_serial_codec_bench;
    localparam int NMAX = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] tx_word = '0;
    logic       tx_valid = 1'b0;
    logic       tx_take;
    logic       tx_line;
    logic       rx_line;
    logic       rx_bit;
    logic       inv = 1'b0;
    logic       flip = 1'b0;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    run = 1'b0;
    int    c = 0;
    int    widx = 0;
    int    kind = 0;
    int    flip_at = -1;
    int    ok_from = 0;
    string rx_tag = "R7";

    logic exp_d  [NMAX];
    logic scr_m  [NMAX];
    logic line_m [NMAX];

    always #4 clk = ~clk;

    assign rx_line = tx_line ^ inv ^ flip;

    sdi_serial_codec u_sdi_serial_codec (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_word  (tx_word),
        .tx_valid (tx_valid),
        .tx_take  (tx_take),
        .tx_line  (tx_line),
        .rx_line  (rx_line),
        .rx_bit   (rx_bit)
    );

    function automatic logic sm(input int i);
        return (i < 0) ? 1'b0 : scr_m[i];
    endfunction

    // Word source: returns {valid, word} for word number k of pattern kd.
    function automatic logic [10:0] gen(input int kd, input int k);
        logic [9:0] r;
        r = 10'((k * 37) + (k * k * 11)) ^ 10'h155;
        case (kd)
            0: return {1'b1, 10'(k)};
            1: return (k < 20) ? {1'b1, 10'h000} : {1'b1, r};
            2: return {(k % 3) != 2, r};
            3: return {1'b1, (k % 2 == 0) ? 10'h3FF : 10'h000};
            default: return {1'b1, r};
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, c, act, exp);
        end
    endtask

    // Monitor and model: cycle c is the interval after edge c (cycle 0 = reset state).
    always @(negedge clk) begin
        if (run) begin
            logic [10:0] g;
            chk(tx_take == (c % 10 == 0), "R1", "tx_take", int'(tx_take), int'(c % 10 == 0));
            if (c == 0) begin
                chk(tx_line == 1'b0, "R6", "tx_line at reset", int'(tx_line), 0);
                chk(rx_bit == 1'b0, "R6", "rx_bit at reset", int'(rx_bit), 0);
            end
            if (c == 0) begin
                scr_m[0]  = 1'b0;
                line_m[0] = 1'b0;
            end else begin
                scr_m[c]  = exp_d[c-1] ^ sm(c - 4) ^ sm(c - 9);
                line_m[c] = line_m[c-1] ^ scr_m[c-1];
            end
            chk(tx_line == line_m[c], "R4/R5", "tx_line", int'(tx_line), int'(line_m[c]));
            if (c >= 4 && (c - 4) >= ok_from &&
                !(flip_at >= 0 && c >= flip_at && c <= flip_at + 12))
                chk(rx_bit == exp_d[c-4], rx_tag, "rx_bit", int'(rx_bit), int'(exp_d[c-4]));
            if (tx_take) begin
                g = gen(kind, widx);
                widx++;
                tx_valid = g[10];
                tx_word  = g[9:0];
                for (int i = 0; i < 10; i++)
                    if (c + 1 + i < NMAX) exp_d[c+1+i] = g[10] ? g[i] : 1'b0;
            end
            flip = (flip_at >= 0 && c == flip_at);
            c++;
        end
    end

    task automatic run_scenario(input string name, input int kd, input bit invert,
                                input int flt, input int okf, input string tag,
                                input int ncyc);
        int f0;
        f0 = n_fail;
        run = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; inv = invert; flip = 1'b0; tx_valid = 1'b0; tx_word = '0;
        for (int i = 0; i < NMAX; i++) begin
            exp_d[i] = 1'b0; scr_m[i] = 1'b0; line_m[i] = 1'b0;
        end
        kind = kd; flip_at = flt; ok_from = okf; rx_tag = tag; widx = 0; c = 0;
        repeat (3) @(negedge clk);
        chk(tx_line == 1'b0 && rx_bit == 1'b0 && tx_take == 1'b1, "R6",
            "outputs in reset", int'({tx_line, rx_bit, tx_take}), 1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        run = 1'b1;
        repeat (ncyc) @(negedge clk);
        #1;
        run = 1'b0;
        $display("scenario %s: %0d failures", name, n_fail - f0);
    endtask

    initial begin
        run_scenario("counting words", 0, 1'b0, -1, 0, "R7", 600);
        run_scenario("zero run then data", 1, 1'b0, -1, 0, "R7", 700);
        run_scenario("invalid slots fill", 2, 1'b0, -1, 0, "R3", 600);
        run_scenario("alternating extremes", 3, 1'b0, -1, 0, "R2", 400);
        run_scenario("inverted line", 4, 1'b1, -1, 10, "R8", 600);
        run_scenario("single line fault", 4, 1'b0, 303, 0, "R9", 700);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule